// File: doc/BRIEF.md
# Serial Link Transceiver with Run-Time Bit Timing

A full-duplex asynchronous serial transceiver whose bit timing and character format are held in registers instead of being fixed at build time. A host reaches three 32-bit configuration words over a simple write/read register port: the bit period in clock cycles, the number of data bits per character, and the number of stop bits. The bit period is the system clock frequency divided by the baud rate. At 50 MHz, 9600 baud needs 5208 cycles and 256000 baud needs 195 cycles. Out of reset the link runs at 5208 cycles per bit, with 8 data bits, no parity and one stop bit.

Toward the rest of the chip the block offers a byte-wide valid/ready stream in each direction. The transmitter serialises one accepted byte at a time. The receiver synchronises the line, confirms a start bit in the middle of its bit period, samples each data bit at its midpoint and checks the first stop bit. It then delivers the byte through a one-entry holding register, or it raises a single-cycle framing-error pulse.

Configuration may change while traffic is running. Each direction copies the settings when a character begins, so a write never bends a character that is already on the wire.

Top module: `uart_prog_link`

## Requirements
- R1: After reset, txd_o is 1, tx_ready_o is 1, rx_valid_o and frame_err_o are 0, and the configuration reads back as bit period 5208, 8 data bits and 1 stop bit.
- R2: A read returns the bit period at address 0x10 in bits 15:0 with bits 31:16 zero. It returns the data-bit count at 0x11 and the stop-bit count at 0x12. Any other address reads 0. A bit-period write uses only bits 15:0 of the write data.
- R3: Some writes are dropped and leave the register unchanged: a bit period below 4, a data-bit count outside 5 to 8, and a stop-bit count other than 1 or 2.
- R4: A byte taken on tx_valid_i && tx_ready_o drives txd_o low from the next cycle. The frame is one start bit, then the configured number of data bits least significant first, then the configured number of high stop bits. Each bit lasts exactly one bit period, and tx_ready_o stays low until the last stop bit has ended.
- R5: Each direction copies the bit period and format when a character starts. A write during a character does not change that character. A write in the same cycle that a transmit byte is accepted applies only from the next character.
- R6: rxd_i passes through two flip-flops. A low line is confirmed as a start bit half a bit period later, and each data bit is sampled one bit period after the previous sample. The received bits are placed least significant first, and fewer than 8 bits are right-aligned with zero fill.
- R7: A low pulse on rxd_i that is high again at the start-bit midpoint delivers no byte and raises no framing error.
- R8: If the stop-bit sample is low, frame_err_o pulses for exactly one cycle and no byte is delivered. The receiver then waits for the line to go high before it looks for a new start bit.
- R9: A received byte is held on rx_data_o with rx_valid_o high until rx_ready_i is seen high. A byte that completes while the holding register is full and not being read is discarded.
- R10: Transmit and receive run at the same time without affecting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register address for read and write |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| tx_data_i | input | 8 | Byte to transmit |
| tx_valid_i | input | 1 | Transmit byte offered |
| tx_ready_o | output | 1 | Transmitter can take a byte |
| txd_o | output | 1 | Serial output, idles high |
| rxd_i | input | 1 | Serial input, idles high |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | Received byte available |
| rx_ready_i | input | 1 | Consumer takes the received byte |
| frame_err_o | output | 1 | One-cycle pulse for a low stop bit |

## Verification
The register write and the start of a character can land in the same clock cycle. The bench provokes this in three ways:
- It raises a bit-period write and a transmit handshake in one cycle.
- It rewrites the bit period halfway through an outgoing character.
- It rewrites the bit period halfway through an incoming character.

The monitor decodes each transmitted frame at the bit period the requirements predict for that frame. A frame sent at the wrong period shifts the midpoint samples onto a neighbouring bit, and an alternating 0x55 pattern turns that shift into a data mismatch. Transmit and receive are also run together, so that a byte handshake and an incoming sample share cycles.

// File: rtl/uart_prog_pkg.sv
package uart_prog_pkg;
  localparam int DIV_W = 16;
  localparam int BYTE_W = 8;
  localparam int CNT_W = 4;

  localparam logic [7:0] ADDR_PERIOD = 8'h10;
  localparam logic [7:0] ADDR_DBITS  = 8'h11;
  localparam logic [7:0] ADDR_SBITS  = 8'h12;

  localparam logic [DIV_W-1:0] DIV_ONE = 1;

  typedef struct packed {
    logic [DIV_W-1:0] period;
    logic [CNT_W-1:0] dbits;
    logic [1:0]       sbits;
  } link_cfg_t;
endpackage

// File: rtl/uart_prog_regs.sv
module uart_prog_regs
  import uart_prog_pkg::*;
#(
  parameter int RESET_DIV   = 5208,
  parameter int MIN_DIV     = 4,
  parameter int RESET_DBITS = 8,
  parameter int RESET_SBITS = 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [7:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output link_cfg_t   cfg_o
);
  localparam logic [DIV_W-1:0] MIN_DIV_L = DIV_W'(MIN_DIV);

  link_cfg_t cfg_q;
  logic      div_ok, dbits_ok, sbits_ok;

  assign div_ok   = wdata_i[DIV_W-1:0] >= MIN_DIV_L;
  assign dbits_ok = (wdata_i >= 32'd5) && (wdata_i <= 32'd8);
  assign sbits_ok = (wdata_i == 32'd1) || (wdata_i == 32'd2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q.period <= DIV_W'(RESET_DIV);
      cfg_q.dbits  <= CNT_W'(RESET_DBITS);
      cfg_q.sbits  <= 2'(RESET_SBITS);
    end else if (wr_i) begin
      if (addr_i == ADDR_PERIOD && div_ok)  cfg_q.period <= wdata_i[DIV_W-1:0];
      if (addr_i == ADDR_DBITS  && dbits_ok) cfg_q.dbits <= wdata_i[CNT_W-1:0];
      if (addr_i == ADDR_SBITS  && sbits_ok) cfg_q.sbits <= wdata_i[1:0];
    end
  end

  always_comb begin
    case (addr_i)
      ADDR_PERIOD: rdata_o = 32'(cfg_q.period);
      ADDR_DBITS:  rdata_o = 32'(cfg_q.dbits);
      ADDR_SBITS:  rdata_o = 32'(cfg_q.sbits);
      default:     rdata_o = '0;
    endcase
  end

  assign cfg_o = cfg_q;

  // R3
  period_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADDR_PERIOD && wdata_i[DIV_W-1:0] < MIN_DIV_L) |=> $stable(cfg_q.period));
  // R3
  dbits_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADDR_DBITS && (wdata_i < 32'd5 || wdata_i > 32'd8)) |=> $stable(cfg_q.dbits));
endmodule

// File: rtl/uart_prog_tx.sv
module uart_prog_tx
  import uart_prog_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  link_cfg_t         cfg_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              txd_o
);
  typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_e;

  tx_state_e         state_q;
  logic [DIV_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  left_q;
  logic [BYTE_W-1:0] sr_q;
  link_cfg_t         cfg_q;
  logic              txd_q;
  logic              tick;

  assign tick    = (cnt_q == '0);
  assign ready_o = (state_q == TX_IDLE);
  assign txd_o   = txd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      cnt_q   <= '0;
      left_q  <= '0;
      sr_q    <= '0;
      cfg_q   <= '0;
      txd_q   <= 1'b1;
    end else begin
      case (state_q)
        TX_IDLE: if (valid_i) begin
          state_q <= TX_START;
          cfg_q   <= cfg_i;  // settings frozen for this character
          cnt_q   <= cfg_i.period - DIV_ONE;
          sr_q    <= data_i;
          txd_q   <= 1'b0;
        end
        TX_START: if (tick) begin
          state_q <= TX_DATA;
          cnt_q   <= cfg_q.period - DIV_ONE;
          txd_q   <= sr_q[0];
          sr_q    <= sr_q >> 1;
          left_q  <= cfg_q.dbits - 4'd1;
        end else cnt_q <= cnt_q - DIV_ONE;
        TX_DATA: if (tick) begin
          cnt_q <= cfg_q.period - DIV_ONE;
          if (left_q == '0) begin
            state_q <= TX_STOP;
            txd_q   <= 1'b1;
            left_q  <= {2'b00, cfg_q.sbits} - 4'd1;
          end else begin
            txd_q  <= sr_q[0];
            sr_q   <= sr_q >> 1;
            left_q <= left_q - 4'd1;
          end
        end else cnt_q <= cnt_q - DIV_ONE;
        TX_STOP: if (tick) begin
          if (left_q == '0) state_q <= TX_IDLE;
          else begin
            left_q <= left_q - 4'd1;
            cnt_q  <= cfg_q.period - DIV_ONE;
          end
        end else cnt_q <= cnt_q - DIV_ONE;
        default: state_q <= TX_IDLE;
      endcase
    end
  end

  // R4
  start_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> !txd_o);
  // R4
  idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !valid_i) |=> txd_o);
  // R5
  frozen_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != TX_IDLE) |=> (state_q == TX_IDLE || $stable(cfg_q)));
endmodule

// File: rtl/uart_prog_rx.sv
module uart_prog_rx
  import uart_prog_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  period_i,
  input  logic [CNT_W-1:0]  dbits_i,
  input  logic              rxd_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              valid_o,
  input  logic              ready_i,
  output logic              err_o
);
  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_WAIT} rx_state_e;

  logic              sync1_q, sync2_q;
  rx_state_e         state_q;
  logic [DIV_W-1:0]  cnt_q, period_q;
  logic [CNT_W-1:0]  dbits_q, left_q;
  logic [BYTE_W-1:0] sr_q, hold_q, word;
  logic              valid_q, err_q, tick, frame_ok, frame_bad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
    end else begin
      sync1_q <= rxd_i;
      sync2_q <= sync1_q;
    end
  end

  assign tick      = (cnt_q == '0);
  assign frame_ok  = (state_q == RX_STOP) && tick && sync2_q;
  assign frame_bad = (state_q == RX_STOP) && tick && !sync2_q;
  assign word      = sr_q >> (4'd8 - dbits_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= RX_IDLE;
      cnt_q    <= '0;
      period_q <= '0;
      dbits_q  <= 4'd8;
      left_q   <= '0;
      sr_q     <= '0;
    end else begin
      case (state_q)
        RX_IDLE: if (!sync2_q) begin
          state_q  <= RX_START;
          period_q <= period_i;
          dbits_q  <= dbits_i;
          cnt_q    <= (period_i >> 1) - DIV_ONE;
        end
        RX_START: if (tick) begin
          if (!sync2_q) begin
            state_q <= RX_DATA;
            cnt_q   <= period_q - DIV_ONE;
            left_q  <= dbits_q - 4'd1;
          end else state_q <= RX_IDLE;  // glitch, not a start bit
        end else cnt_q <= cnt_q - DIV_ONE;
        RX_DATA: if (tick) begin
          sr_q  <= {sync2_q, sr_q[BYTE_W-1:1]};
          cnt_q <= period_q - DIV_ONE;
          if (left_q == '0) state_q <= RX_STOP;
          else left_q <= left_q - 4'd1;
        end else cnt_q <= cnt_q - DIV_ONE;
        RX_STOP: if (tick) state_q <= sync2_q ? RX_IDLE : RX_WAIT;
        else cnt_q <= cnt_q - DIV_ONE;
        RX_WAIT: if (sync2_q) state_q <= RX_IDLE;
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q  <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      err_q <= frame_bad;
      if (frame_ok && (!valid_q || ready_i)) begin
        hold_q  <= word;
        valid_q <= 1'b1;
      end else if (ready_i) valid_q <= 1'b0;
    end
  end

  assign data_o  = hold_q;
  assign valid_o = valid_q;
  assign err_o   = err_q;

  // R9
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o)));
  // R8
  err_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);
  // R8
  err_no_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !$rose(valid_o));
endmodule

// File: rtl/uart_prog_link.sv
module uart_prog_link
  import uart_prog_pkg::*;
#(
  parameter int RESET_DIV   = 5208,
  parameter int MIN_DIV     = 4,
  parameter int RESET_DBITS = 8,
  parameter int RESET_SBITS = 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_wr_i,
  input  logic [7:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic [7:0]  tx_data_i,
  input  logic        tx_valid_i,
  output logic        tx_ready_o,
  output logic        txd_o,
  input  logic        rxd_i,
  output logic [7:0]  rx_data_o,
  output logic        rx_valid_o,
  input  logic        rx_ready_i,
  output logic        frame_err_o
);
  link_cfg_t cfg;

  uart_prog_regs #(
    .RESET_DIV  (RESET_DIV),
    .MIN_DIV    (MIN_DIV),
    .RESET_DBITS(RESET_DBITS),
    .RESET_SBITS(RESET_SBITS)
  ) i_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (reg_wr_i),
    .addr_i (reg_addr_i),
    .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o),
    .cfg_o  (cfg)
  );

  uart_prog_tx i_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cfg_i  (cfg),
    .data_i (tx_data_i),
    .valid_i(tx_valid_i),
    .ready_o(tx_ready_o),
    .txd_o  (txd_o)
  );

  uart_prog_rx i_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .period_i(cfg.period),
    .dbits_i (cfg.dbits),
    .rxd_i   (rxd_i),
    .data_o  (rx_data_o),
    .valid_o (rx_valid_o),
    .ready_i (rx_ready_i),
    .err_o   (frame_err_o)
  );
endmodule

// File: tb/test_uart_prog_link.sv
module test_uart_prog_link;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;

  typedef struct {
    logic [7:0] b;
    int d;
    int nb;
    int ns;
  } frame_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  tx_data = '0;
  logic        tx_valid = 1'b0;
  logic        tx_ready, txd, rxd = 1'b1;
  logic [7:0]  rx_data;
  logic        rx_valid, rx_rdy = 1'b1, frame_err;

  frame_t tx_q[$];
  frame_t rx_q[$];
  int  n_total = 0, n_bad = 0, err_seen = 0, exp_err = 0, rx_got = 0;
  bit  tx_busy = 1'b0, done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_prog_link i_uart_prog_link (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready), .txd_o(txd),
    .rxd_i(rxd), .rx_data_o(rx_data), .rx_valid_o(rx_valid), .rx_ready_i(rx_rdy),
    .frame_err_o(frame_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_total++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] masked(input logic [7:0] b, input int nb);
    return b & 8'((1 << nb) - 1);
  endfunction

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_check(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic tx_send(input logic [7:0] b, input int d, input int nb, input int ns);
    tx_q.push_back('{b, d, nb, ns});
    @(negedge clk);
    tx_valid = 1'b1; tx_data = b;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  // mode 0: delivered, 1: framing error, 2: dropped by full holding register
  task automatic rx_drive(input logic [7:0] b, input int d, input int nb, input int ns, input int mode);
    if (mode == 0) rx_q.push_back('{masked(b, nb), d, nb, ns});
    if (mode == 1) exp_err++;
    @(negedge clk);
    rxd = 1'b0;
    repeat (d) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      rxd = b[i];
      repeat (d) @(negedge clk);
    end
    rxd = (mode != 1);
    repeat (d * ns) @(negedge clk);
    rxd = 1'b1;
    repeat (d) @(negedge clk);
  endtask

  task automatic wait_tx_idle();
    do @(negedge clk); while (tx_q.size() != 0 || tx_busy || !tx_ready);
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_rx_empty();
    do @(negedge clk); while (rx_q.size() != 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
    end
  endtask

  // transmit monitor: decodes each frame at the period expected for it
  initial begin : tx_mon
    frame_t f;
    logic [7:0] got;
    bit start_ok, stop_ok;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (txd === 1'b0) begin
        if (tx_q.size() == 0) chk(1'b0, "R4 unexpected start bit", 0, 1);
        else begin
          f = tx_q.pop_front();
          tx_busy = 1'b1;
          repeat (f.d / 2 - 1) @(negedge clk);
          start_ok = (txd == 1'b0);
          got = '0;
          for (int i = 0; i < f.nb; i++) begin
            repeat (f.d) @(negedge clk);
            got[i] = txd;
          end
          stop_ok = 1'b1;
          for (int i = 0; i < f.ns; i++) begin
            repeat (f.d) @(negedge clk);
            if (txd !== 1'b1) stop_ok = 1'b0;
          end
          chk(start_ok && stop_ok, "R4 tx start/stop bits", {start_ok, stop_ok}, 2'b11);
          chk(got == masked(f.b, f.nb), "R4 R5 tx data at expected period", got, masked(f.b, f.nb));
          tx_busy = 1'b0;
        end
      end
    end
  end

  // receive monitor
  initial begin : rx_mon
    frame_t f;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (frame_err) err_seen++;
      if (rx_valid && rx_rdy) begin
        rx_got++;
        if (rx_q.size() == 0) chk(1'b0, "R6 unexpected rx byte", rx_data, 0);
        else begin
          f = rx_q.pop_front();
          chk(rx_data == f.b, "R6 rx data", rx_data, f.b);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (WD_CYCLES) @(posedge clk);
    n_total++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin : main
    int got_before, err_before;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(txd == 1'b1, "R1 txd idle", txd, 1);
    chk(tx_ready == 1'b1, "R1 tx_ready", tx_ready, 1);
    chk(rx_valid == 1'b0 && frame_err == 1'b0, "R1 rx outputs", {rx_valid, frame_err}, 0);
    reg_check(8'h10, 32'd5208, "R1 reset period");
    reg_check(8'h11, 32'd8, "R1 reset data bits");
    reg_check(8'h12, 32'd1, "R1 reset stop bits");
    // R2
    reg_check(8'h20, 32'd0, "R2 unmapped address");
    reg_write(8'h10, 32'hABCD_0010);
    reg_check(8'h10, 32'h10, "R2 period upper bits ignored");
    // R3
    reg_write(8'h10, 32'd3);
    reg_check(8'h10, 32'h10, "R3 period below minimum");
    reg_write(8'h11, 32'd9);
    reg_write(8'h11, 32'd4);
    reg_check(8'h11, 32'd8, "R3 data bits out of range");
    reg_write(8'h12, 32'd0);
    reg_write(8'h12, 32'd3);
    reg_check(8'h12, 32'd1, "R3 stop bits out of range");

    // R4: back-to-back frames at 16 cycles per bit
    tx_send(8'hA5, 16, 8, 1);
    tx_send(8'h3C, 16, 8, 1);
    wait_tx_idle();
    // R6
    rx_drive(8'h5A, 16, 8, 1, 0);
    rx_drive(8'hC3, 16, 8, 1, 0);
    wait_rx_empty();
    // R10: both directions together
    fork
      tx_send(8'h96, 16, 8, 1);
      rx_drive(8'h69, 16, 8, 1, 0);
    join
    wait_tx_idle();
    wait_rx_empty();

    // R5: period rewrite during an outgoing character
    fork
      tx_send(8'h55, 16, 8, 1);
      begin repeat (40) @(negedge clk); reg_write(8'h10, 32'd24); end
    join
    tx_send(8'h55, 24, 8, 1);
    wait_tx_idle();
    // R5: write and accept in the same cycle, old period still used
    tx_q.push_back('{8'h55, 24, 8, 1});
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'h10; reg_wdata = 32'd12;
    tx_valid = 1'b1; tx_data = 8'h55;
    @(negedge clk);
    reg_wr = 1'b0; tx_valid = 1'b0;
    tx_send(8'h55, 12, 8, 1);
    wait_tx_idle();
    // R5: period rewrite during an incoming character
    fork
      rx_drive(8'hB4, 12, 8, 1, 0);
      begin repeat (50) @(negedge clk); reg_write(8'h10, 32'd16); end
    join
    wait_rx_empty();

    // R4 R6: five data bits, two stop bits
    reg_write(8'h11, 32'd5);
    reg_write(8'h12, 32'd2);
    tx_send(8'hFA, 16, 5, 2);
    tx_send(8'h0B, 16, 5, 2);
    rx_drive(8'h15, 16, 5, 2, 0);
    wait_tx_idle();
    wait_rx_empty();
    reg_write(8'h11, 32'd8);
    reg_write(8'h12, 32'd1);

    // R7: short low glitch
    got_before = rx_got; err_before = err_seen;
    @(negedge clk);
    rxd = 1'b0;
    repeat (4) @(negedge clk);
    rxd = 1'b1;
    repeat (48) @(negedge clk);
    chk(rx_got == got_before && err_seen == err_before && !rx_valid, "R7 glitch ignored",
        rx_got - got_before, 0);
    rx_drive(8'h81, 16, 8, 1, 0);
    wait_rx_empty();

    // R8: low stop bit
    got_before = rx_got;
    rx_drive(8'h7E, 16, 8, 1, 1);
    repeat (8) @(negedge clk);
    chk(err_seen == exp_err, "R8 framing error pulse", err_seen, exp_err);
    chk(rx_got == got_before, "R8 no byte on error", rx_got - got_before, 0);
    rx_drive(8'h42, 16, 8, 1, 0);
    wait_rx_empty();

    // R9: holding register full
    @(posedge clk); #1 rx_rdy = 1'b0;
    rx_drive(8'h11, 16, 8, 1, 0);
    rx_drive(8'h22, 16, 8, 1, 2);
    repeat (10) @(negedge clk);
    chk(rx_valid == 1'b1 && rx_data == 8'h11, "R9 first byte held", rx_data, 8'h11);
    @(posedge clk); #1 rx_rdy = 1'b1;
    wait_rx_empty();
    repeat (10) @(negedge clk);
    chk(!rx_valid, "R9 second byte discarded", rx_valid, 0);

    chk(tx_q.size() == 0, "R4 pending tx frames", tx_q.size(), 0);
    chk(rx_q.size() == 0, "R6 pending rx bytes", rx_q.size(), 0);
    chk(err_seen == exp_err, "R8 total error pulses", err_seen, exp_err);
    finish_run();
  end
endmodule